// File: doc/BRIEF.md
# Bit-serial HDLC link transmitter with a segmented ping-pong buffer

This block frames a processor-supplied message as an HDLC frame and sends it one bit per bit-enable strobe. The processor writes message bytes into an eight-byte store, which is organised as four 16-bit words. It then issues a control word that names the index of the final byte of the current segment and says whether the FCS follows that segment. The store is normally filled in two four-byte halves. While the serializer drains one half, the processor refills the other. A read pointer walks the store cyclically, so each segment starts at the byte after the one where the previous segment stopped.

The serializer sends 0x7E flags while the line is idle. When a segment is pending, the flag being sent is used as the opening flag. Data follows least-significant bit first, and a zero is inserted after any five consecutive ones. On request, a complemented CRC-16-CCITT FCS is appended, followed by a closing flag. An interrupt rises as soon as the last byte of a segment has been moved out of the store. This tells the processor that it can refill and issue the next control word. Any control write clears the interrupt.

Top module: `hdlc_tx_split`

## Requirements
- R1: After reset the interrupt is low and, on successive strobes, the line carries back-to-back flags 0x7E, sent LSB first (bit pattern 0,1,1,1,1,1,1,0). Flag bits are never zero-stuffed.
- R2: Bus addresses 0 to 3 hold store words 0 to 3. Byte 2k of the store is bits 7:0 of word k, and byte 2k+1 is bits 15:8. The control word is at address 4.
- R3: A control write with bit 0 set starts a segment. The segment runs from the current read pointer up to and including the byte index in bits 5:3, wrapping from byte 7 to byte 0. The read pointer is 0 after reset and carries on across segments and frames.
- R4: The interrupt rises in the cycle after the last byte of a segment leaves the store for the serializer. It stays high until a control write, which clears it by the next clock edge.
- R5: A frame opens with a flag, and each byte is sent LSB first.
- R6: After five consecutive ones of data or FCS, a 0 is inserted. No run of more than six ones appears on the line.
- R7: When control bit 1 was set with the segment, the last data byte is followed by the FCS and then a closing flag. The FCS is the ones-complement of a CRC-16 (x^16+x^12+x^5+1, register preset to 0xFFFF, bits processed LSB first), sent low byte first and LSB first.
- R8: If a segment without FCS finishes and no new segment is pending by the end of its last byte, the frame is closed by a flag with no FCS, and the line returns to idle flags.
- R9: A control write with bit 0 clear starts no transmission: the line keeps sending flags and the interrupt stays low.
- R10: The line advances exactly one bit per strobe on bit_en_i. With no strobe, tx_bit_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 3 | Word address: 0-3 store, 4 control |
| wdata_i | input | 16 | Bus write data |
| bit_en_i | input | 1 | Bit slot strobe; the line advances one bit per strobe |
| tx_bit_o | output | 1 | Serial line bit, valid for the next strobe |
| irq_o | output | 1 | Segment-consumed interrupt |

## Verification
The line bit depends only on serializer registers, so it is sampled on the falling edge where the bench raises the strobe, just before the rising edge that consumes it. The interrupt becomes visible on the falling edge after the strobe edge that loads the last byte of a segment. A control write driven on a falling edge has cleared the interrupt by the following falling edge, and the bench checks it there. Frames are rebuilt from the sampled bits by a flag-delimited de-stuffer in the bench and compared byte by byte, FCS included, against values computed from the requirements. The bench waits for frames and interrupts with bounded polling loops rather than fixed delays.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [1:0] {
    K_FLAG   = 2'd0,
    K_DATA   = 2'd1,
    K_FCS_LO = 2'd2,
    K_FCS_HI = 2'd3
  } oct_kind_e;

  localparam logic [7:0]  FLAG_BYTE = 8'h7E;
  localparam logic [15:0] CRC_POLY_REF = 16'h8408;  // x^16+x^12+x^5+1, bit-reversed
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam int          STUFF_RUN = 5;
endpackage

// File: rtl/hdlc_tx_regs.sv
module hdlc_tx_regs #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  parameter int ADDR_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              take_i,
  output logic [7:0]        byte_o,
  output logic              seg_valid_o,
  output logic              seg_last_o,
  output logic              seg_fcs_o,
  output logic              irq_o
);
  localparam int BPW       = WORD_W / 8;
  localparam int NUM_BYTES = NUM_WORDS * BPW;
  localparam int PTR_W     = $clog2(NUM_BYTES);
  localparam int CTRL_ADDR = NUM_WORDS;
  localparam int LAST_LSB  = 3;

  logic [NUM_BYTES*8-1:0] store_flat;
  logic [PTR_W-1:0]       rd_ptr_q, seg_end_q;
  logic                   seg_valid_q, seg_fcs_q, irq_q;
  logic                   ctrl_wr;

  genvar w;
  generate
    for (w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk_i) begin
        if (wr_en_i && addr_i == ADDR_W'(w)) word_q <= wdata_i;
      end
      assign store_flat[w*WORD_W +: WORD_W] = word_q;
    end
  endgenerate

  assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q    <= '0;
      seg_end_q   <= '0;
      seg_valid_q <= 1'b0;
      seg_fcs_q   <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      if (take_i) begin
        rd_ptr_q <= rd_ptr_q + PTR_W'(1);
        if (seg_last_o) begin
          seg_valid_q <= 1'b0;
          irq_q       <= 1'b1;
        end
      end
      // control write wins over a same-cycle segment end
      if (ctrl_wr) begin
        irq_q <= 1'b0;
        if (wdata_i[0]) begin
          seg_valid_q <= 1'b1;
          seg_end_q   <= wdata_i[LAST_LSB +: PTR_W];
          seg_fcs_q   <= wdata_i[1];
        end
      end
    end
  end

  assign byte_o      = store_flat[rd_ptr_q*8 +: 8];
  assign seg_valid_o = seg_valid_q;
  assign seg_last_o  = (rd_ptr_q == seg_end_q);
  assign seg_fcs_o   = seg_fcs_q;
  assign irq_o       = irq_q;

  a_r4_irq_cleared_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> !irq_o) else $error("irq not cleared by control write");

  a_r4_irq_rises_on_last_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(take_i && seg_last_o)) else $error("irq rose without segment end");

  a_r3_ptr_steps_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ptr_q != $past(rd_ptr_q)) |-> (rd_ptr_q == $past(rd_ptr_q) + PTR_W'(1)))
    else $error("read pointer jumped");

  a_r3_take_needs_segment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> seg_valid_q) else $error("byte taken with no segment");
endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
  parameter int          CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = hdlc_tx_pkg::CRC_POLY_REF,
  parameter logic [CRC_W-1:0] INIT = hdlc_tx_pkg::CRC_PRESET
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] fcs_nx_o
);
  logic [CRC_W-1:0] crc_q, crc_nx;
  logic             fb;

  always_comb begin
    fb     = crc_q[0] ^ bit_i;
    crc_nx = crc_q;
    if (step_i) crc_nx = (crc_q >> 1) ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= INIT;
    else if (clear_i) crc_q <= INIT;
    else              crc_q <= crc_nx;
  end

  // FCS includes the bit being stepped this cycle
  assign fcs_nx_o = ~crc_nx;

  a_r7_crc_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (crc_q == INIT)) else $error("crc not preset");

  a_r7_clear_step_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clear_i && step_i)) else $error("crc clear during step");
endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser
  import hdlc_tx_pkg::*;
#(
  parameter int RUN = STUFF_RUN
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bit_en_i,
  input  logic        seg_valid_i,
  input  logic        seg_last_i,
  input  logic        seg_fcs_i,
  input  logic [7:0]  byte_i,
  input  logic [15:0] fcs_nx_i,
  output logic        take_o,
  output logic        crc_clr_o,
  output logic        crc_step_o,
  output logic        crc_bit_o,
  output logic        tx_bit_o
);
  localparam int ONES_W = $clog2(RUN + 2);

  oct_kind_e         kind_q, kind_nx;
  logic [7:0]        sh_q, byte_nx, fcs_hi_q;
  logic [2:0]        cnt_q;
  logic [ONES_W-1:0] ones_q;
  logic              fcs_pend_q;
  logic              stuff_now, adv, oct_end, load_lo;

  assign stuff_now = (ones_q == ONES_W'(RUN));
  assign adv       = bit_en_i && !stuff_now;
  assign oct_end   = adv && (cnt_q == 3'd7);

  always_comb begin
    kind_nx   = K_FLAG;
    byte_nx   = FLAG_BYTE;
    take_o    = 1'b0;
    crc_clr_o = 1'b0;
    load_lo   = 1'b0;
    case (kind_q)
      K_FCS_LO: begin
        kind_nx = K_FCS_HI;
        byte_nx = fcs_hi_q;
      end
      K_DATA: begin
        if (fcs_pend_q) begin
          kind_nx = K_FCS_LO;
          byte_nx = fcs_nx_i[7:0];
          load_lo = oct_end;
        end else if (seg_valid_i) begin
          kind_nx = K_DATA;
          byte_nx = byte_i;
          take_o  = oct_end;
        end
      end
      K_FLAG: begin
        if (seg_valid_i) begin
          kind_nx   = K_DATA;
          byte_nx   = byte_i;
          take_o    = oct_end;
          crc_clr_o = oct_end;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q     <= K_FLAG;
      sh_q       <= FLAG_BYTE;
      cnt_q      <= '0;
      ones_q     <= '0;
      fcs_pend_q <= 1'b0;
      fcs_hi_q   <= '0;
    end else if (bit_en_i) begin
      if (stuff_now) begin
        ones_q <= '0;
      end else begin
        if (kind_q == K_FLAG) ones_q <= '0;
        else                  ones_q <= sh_q[0] ? ones_q + ONES_W'(1) : '0;
        if (cnt_q == 3'd7) begin
          cnt_q  <= '0;
          kind_q <= kind_nx;
          sh_q   <= byte_nx;
          if (take_o && seg_last_i && seg_fcs_i) fcs_pend_q <= 1'b1;
          if (load_lo) begin
            fcs_pend_q <= 1'b0;
            fcs_hi_q   <= fcs_nx_i[15:8];
          end
        end else begin
          cnt_q <= cnt_q + 3'd1;
          sh_q  <= {1'b0, sh_q[7:1]};
        end
      end
    end
  end

  assign crc_step_o = adv && (kind_q == K_DATA);
  assign crc_bit_o  = sh_q[0];
  assign tx_bit_o   = stuff_now ? 1'b0 : sh_q[0];

  a_r6_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= ONES_W'(RUN)) else $error("ones run exceeds limit");

  a_r10_take_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (bit_en_i && seg_valid_i)) else $error("take without strobe");

  a_r10_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(tx_bit_o)) else $error("line moved without strobe");

  a_r7_fcs_hi_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q == K_FCS_HI) |-> ($past(kind_q) == K_FCS_HI || $past(kind_q) == K_FCS_LO))
    else $error("fcs high byte out of order");

  a_r5_data_after_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q == K_DATA && $past(kind_q) != K_DATA) |-> ($past(kind_q) == K_FLAG))
    else $error("data not opened by flag");
endmodule

// File: rtl/hdlc_tx_split.sv
module hdlc_tx_split #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  parameter int ADDR_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              bit_en_i,
  output logic              tx_bit_o,
  output logic              irq_o
);
  logic [7:0]  cur_byte;
  logic        seg_valid, seg_last, seg_fcs, take;
  logic        crc_clr, crc_step, crc_bit;
  logic [15:0] fcs_nx;

  hdlc_tx_regs #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .take_i(take), .byte_o(cur_byte), .seg_valid_o(seg_valid),
    .seg_last_o(seg_last), .seg_fcs_o(seg_fcs), .irq_o
  );

  hdlc_tx_crc u_crc (
    .clk_i, .rst_ni, .clear_i(crc_clr), .step_i(crc_step),
    .bit_i(crc_bit), .fcs_nx_o(fcs_nx)
  );

  hdlc_tx_ser u_ser (
    .clk_i, .rst_ni, .bit_en_i, .seg_valid_i(seg_valid),
    .seg_last_i(seg_last), .seg_fcs_i(seg_fcs), .byte_i(cur_byte),
    .fcs_nx_i(fcs_nx), .take_o(take), .crc_clr_o(crc_clr),
    .crc_step_o(crc_step), .crc_bit_o(crc_bit), .tx_bit_o
  );
endmodule

// File: tb/hdlc_tx_split_test.sv
`timescale 1ns/1ps
module hdlc_tx_split_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        bit_en = 1'b0;
  logic        tx_bit, irq;

  always #4 clk = ~clk;

  hdlc_tx_split uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .bit_en_i(bit_en), .tx_bit_o(tx_bit), .irq_o(irq)
  );

  int checks = 0, errors = 0, cyc = 0, ph = 0;
  logic strobe_on = 1'b1;

  // line decoder state
  logic       raw_log [64];
  int         raw_n = 0, run = 0, max_run = 0, ones_d = 0, nb = 0;
  logic [7:0] win = '0;
  logic       fbits [256];
  logic [7:0] fr_bytes [32];
  int         fr_len = 0, fr_cnt = 0;
  logic [7:0] exp_bytes [32];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic line_bit(input logic b);
    if (raw_n < 64) raw_log[raw_n] = b;
    raw_n++;
    run = b ? run + 1 : 0;
    if (run > max_run) max_run = run;
    win = {b, win[7:1]};
    if (ones_d == 5 && !b) ones_d = 0;
    else begin
      ones_d = b ? ones_d + 1 : 0;
      if (nb < 256) begin fbits[nb] = b; nb++; end
    end
    if (win == 8'h7E) begin
      if (nb > 8) begin
        if ((nb - 8) % 8 == 0 && (nb - 8) / 8 <= 32) begin
          fr_len = (nb - 8) / 8;
          for (int k = 0; k < fr_len; k++)
            for (int j = 0; j < 8; j++) fr_bytes[k][j] = fbits[k*8+j];
        end else fr_len = -1;
        fr_cnt++;
      end
      nb = 0;
      ones_d = 0;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (!rst_n) bit_en = 1'b0;
    else begin
      ph = (ph + 1) % 4;
      bit_en = strobe_on && (ph == 0);
      if (bit_en) line_bit(tx_bit);
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 4000) begin @(negedge clk); n++; end
    chk(irq === 1'b1, req, "irq after segment", irq, 1);
  endtask

  task automatic wait_frame(input int prev, input string req);
    int n = 0;
    while (fr_cnt == prev && n < 6000) begin @(negedge clk); n++; end
    chk(fr_cnt == prev + 1, req, "frame count", fr_cnt, prev + 1);
  endtask

  function automatic logic [15:0] crc16(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int j = 0; j < 8; j++)
        c = {1'b0, c[15:1]} ^ ((c[0] ^ exp_bytes[k][j]) ? 16'h8408 : 16'h0000);
    return c;
  endfunction

  task automatic check_frame(input int n, input bit with_fcs, input string req);
    logic [15:0] f = ~crc16(n);
    int tot = n + (with_fcs ? 2 : 0);
    chk(fr_len == tot, req, "frame length", fr_len, tot);
    if (fr_len == tot) begin
      for (int k = 0; k < n; k++)
        chk(fr_bytes[k] == exp_bytes[k], req, $sformatf("byte %0d", k), fr_bytes[k], exp_bytes[k]);
      if (with_fcs) begin
        chk(fr_bytes[n] == f[7:0], "R7", "fcs low", fr_bytes[n], f[7:0]);
        chk(fr_bytes[n+1] == f[15:8], "R7", "fcs high", fr_bytes[n+1], f[15:8]);
      end
    end
  endtask

  // R1, R10
  task automatic t_reset_idle();
    logic [7:0] flag = 8'h7E;
    logic v;
    chk(irq === 1'b0, "R1", "irq after reset", irq, 0);
    chk(tx_bit === 1'b0, "R1", "first line bit", tx_bit, 0);
    while (raw_n < 24) @(negedge clk);
    for (int i = 0; i < 24; i++)
      chk(raw_log[i] === flag[i%8], "R1", $sformatf("idle bit %0d", i), raw_log[i], flag[i%8]);
    strobe_on = 1'b0;
    @(negedge clk); @(negedge clk);
    v = tx_bit;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(tx_bit === v, "R10", "hold without strobe", tx_bit, v);
    end
    strobe_on = 1'b1;
  endtask

  // R9
  task automatic t_idle_write();
    int prev = fr_cnt;
    bus_wr(3'd4, 16'h0000);
    repeat (400) @(negedge clk);
    chk(irq === 1'b0, "R9", "irq after disabled write", irq, 0);
    chk(fr_cnt == prev, "R9", "no frame", fr_cnt, prev);
  endtask

  // R2 R3 R4 R5 R7: ten bytes in three segments, pointer wraps
  task automatic t_ping_pong();
    int prev = fr_cnt;
    for (int k = 0; k < 10; k++) exp_bytes[k] = 8'(k * 19 + 5);
    bus_wr(3'd0, {exp_bytes[1], exp_bytes[0]});
    bus_wr(3'd1, {exp_bytes[3], exp_bytes[2]});
    bus_wr(3'd4, 16'h0019);
    wait_irq("R4");
    bus_wr(3'd2, {exp_bytes[5], exp_bytes[4]});
    bus_wr(3'd3, {exp_bytes[7], exp_bytes[6]});
    bus_wr(3'd4, 16'h0039);
    chk(irq === 1'b0, "R4", "irq cleared by write", irq, 0);
    wait_irq("R4");
    bus_wr(3'd0, {exp_bytes[9], exp_bytes[8]});
    bus_wr(3'd4, 16'h000B);
    wait_irq("R3");
    bus_wr(3'd4, 16'h0000);
    wait_frame(prev, "R5");
    check_frame(10, 1'b1, "R2");
  endtask

  // R6: all-ones data from pointer 2 to 5
  task automatic t_stuffing();
    int prev = fr_cnt;
    for (int k = 0; k < 4; k++) exp_bytes[k] = 8'hFF;
    bus_wr(3'd1, 16'hFFFF);
    bus_wr(3'd2, 16'hFFFF);
    max_run = 0;
    bus_wr(3'd4, 16'h002B);
    wait_irq("R3");
    bus_wr(3'd4, 16'h0000);
    wait_frame(prev, "R6");
    check_frame(4, 1'b1, "R6");
    chk(max_run <= 6, "R6", "longest ones run", max_run, 6);
  endtask

  // R8: segment without FCS and no follow-up
  task automatic t_underrun();
    int prev = fr_cnt;
    exp_bytes[0] = 8'hA5; exp_bytes[1] = 8'h3C;
    bus_wr(3'd3, 16'h3CA5);
    bus_wr(3'd4, 16'h0039);
    wait_irq("R4");
    bus_wr(3'd4, 16'h0000);
    wait_frame(prev, "R8");
    check_frame(2, 1'b0, "R8");
    prev = fr_cnt;
    repeat (300) @(negedge clk);
    chk(fr_cnt == prev, "R8", "line back to flags", fr_cnt, prev);
    chk(irq === 1'b0, "R8", "irq idle", irq, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_idle_write();
    t_ping_pong();
    t_stuffing();
    t_underrun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule